// File: doc/BRIEF.md
# SD Sampling Tuning Sequencer

This block finds a receive sampling phase for a high-speed SD/eMMC host. Software writes the control port with the execute bit set. The engine then drives a tap-select output and steps it through a bank of sampling taps. While a tap is selected, the engine takes one tuning block from a byte stream, checks every byte against a pattern it computes itself, and records whether that tap passed. Each judged block raises a one-cycle data-available pulse.

A sweep stops once every tap has been tried or once an iteration bound is reached, whichever comes first. Taps that were never tried count as failing. The engine then scans the pass map, one tap per cycle, for the longest run of passing taps. It selects the centre of that run, sets the tuned-clock bit and clears the execute bit. If no tap passed, only the execute bit clears, and the output stays on the fixed default tap. Once tuning has succeeded, a re-tuning timer counts time-unit ticks. After the programmed period it raises a request for software.

Top module: `sdtune_seq`

## Requirements
- R1: After reset, exec_busy, tuned_ok, data_avail and retune_due are 0 and tap_sel equals DEFAULT_TAP.
- R2: A control write with ctl_exec=1 while exec_busy is 0 starts tuning. From the next cycle exec_busy is 1, tuned_ok is 0, the tap under test is 0, and the pass map, iteration count and byte position are cleared.
- R3: A tuning block is 64 bytes when wide_mode is 0 and 128 bytes when wide_mode is 1. A byte counts only in a cycle where rx_valid is 1.
- R4: Byte i of a block (counted from 0) is expected to equal (37*i + 90) mod 256. A tap passes only if every byte of its block matches.
- R5: data_avail is high for exactly the one cycle after the last byte of each block is taken during a sweep. Bytes presented while no sweep is receiving have no effect on any output.
- R6: While a sweep is receiving, tap_sel shows the tap under test. It starts at 0 and advances by one after each judged block.
- R7: A sweep stops after MAX_ITER blocks or NUM_TAPS blocks, whichever is fewer. Untried taps count as failing. exec_busy falls exactly NUM_TAPS cycles after the cycle that judged the last block.
- R8: If any tap passed, tuned_ok becomes 1 and tap_sel becomes start + (len-1)/2 of the longest run of consecutive passing taps. Among equally long runs, the lowest one wins.
- R9: If no tap passed, exec_busy clears while tuned_ok stays 0, and tap_sel stays on DEFAULT_TAP.
- R10: While idle, a write with ctl_exec=0 and ctl_tuned=0 clears tuned_ok, which returns tap_sel to DEFAULT_TAP. A write with ctl_exec=0 and ctl_tuned=1 changes nothing. Every control write made while exec_busy is 1 is ignored.
- R11: While tuned_ok is 1 and rt_code = n is not 0, retune_due sets on the 2^(n-1)-th rt_tick and stays set until tuned_ok clears or a new sweep starts. With n = 0 it never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_exec | input | 1 | Execute-tuning value written |
| ctl_tuned | input | 1 | Tuned-clock value written (can only clear it) |
| wide_mode | input | 1 | 1 selects the 128-byte tuning block |
| rx_valid | input | 1 | Received tuning byte valid |
| rx_byte | input | 8 | Received tuning byte |
| rt_tick | input | 1 | Re-tuning time-unit tick |
| rt_code | input | CODE_W | Re-tuning period code n |
| exec_busy | output | 1 | Execute-tuning bit readback |
| tuned_ok | output | 1 | Tuned-clock status bit |
| tap_sel | output | $clog2(NUM_TAPS) | Receive sampling tap select |
| data_avail | output | 1 | One-cycle pulse per judged tuning block |
| retune_due | output | 1 | Re-tuning request |

## Verification
The bench builds the block with NUM_TAPS=10, MAX_ITER=8, DEFAULT_TAP=5 and an 8-bit re-tuning counter. With these values the iteration bound is reached before the tap bank is used up, so taps 8 and 9 are never tried. That exercises the untried-means-failing rule and the ten-cycle scan in the same sweep. A default tap in mid-range makes the fallback easy to tell apart from a real result at tap 0, which the tie case produces. A small period code (n=3) makes the re-tuning boundary at the fourth tick reachable in a few cycles.

// File: rtl/sdtune_pkg.sv
package sdtune_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SCAN = 2'd2
  } tune_st_e;

  // expected tuning byte at a given block position
  function automatic logic [7:0] pattern_byte(input logic [7:0] idx,
                                              input logic [7:0] mul,
                                              input logic [7:0] add);
    logic [15:0] prod;
    prod = idx * mul;
    return prod[7:0] + add;
  endfunction

endpackage

// File: rtl/sdtune_blk_check.sv
module sdtune_blk_check #(
  parameter int SHORT_LEN = 64,
  parameter int LONG_LEN  = 128,
  parameter int PAT_MUL   = 37,
  parameter int PAT_ADD   = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       wide,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       blk_done,
  output logic       blk_pass
);
  import sdtune_pkg::*;

  localparam int IDX_W = $clog2(LONG_LEN);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bad_q, bad_d;
  logic             take, byte_bad, at_last;
  logic [7:0]       exp_byte;

  always_comb begin
    take     = en & rx_valid;
    exp_byte = pattern_byte(8'(idx_q), 8'(PAT_MUL), 8'(PAT_ADD));
    byte_bad = (rx_byte != exp_byte);
    at_last  = (idx_q == (wide ? LONG_LAST : SHORT_LAST));
    blk_done = take & at_last;
    blk_pass = ~(bad_q | byte_bad);
    idx_d    = idx_q;
    bad_d    = bad_q;
    if (clr) begin
      idx_d = '0;
      bad_d = 1'b0;
    end else if (take) begin
      if (at_last) begin
        idx_d = '0;
        bad_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
        bad_d = bad_q | byte_bad;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else if (clr | take) begin
      idx_q <= idx_d;
      bad_q <= bad_d;
    end
  end

  // R3
  blk_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !clr) |=> (idx_q == '0 && !bad_q));

endmodule

// File: rtl/sdtune_run_scan.sv
module sdtune_run_scan #(
  parameter int NUM_TAPS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          step,
  input  logic                          pass_bit,
  input  logic [$clog2(NUM_TAPS)-1:0]   pos,
  output logic [$clog2(NUM_TAPS)-1:0]   res_start,
  output logic [$clog2(NUM_TAPS+1)-1:0] res_len
);
  localparam int TAP_W = $clog2(NUM_TAPS);
  localparam int LEN_W = $clog2(NUM_TAPS + 1);

  logic [TAP_W-1:0] cur_start_q, cur_start_d, best_start_q, best_start_d;
  logic [LEN_W-1:0] cur_len_q, cur_len_d, best_len_q, best_len_d;

  always_comb begin
    cur_len_d    = pass_bit ? (cur_len_q + 1'b1) : '0;
    cur_start_d  = (pass_bit && cur_len_q == '0) ? pos : cur_start_q;
    best_len_d   = best_len_q;
    best_start_d = best_start_q;
    if (cur_len_d > best_len_q) begin
      best_len_d   = cur_len_d;
      best_start_d = cur_start_d;
    end
    res_start = best_start_d;
    res_len   = best_len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (clr) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (step) begin
      cur_start_q  <= cur_start_d;
      cur_len_q    <= cur_len_d;
      best_start_q <= best_start_d;
      best_len_q   <= best_len_d;
    end
  end

  // R8
  best_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (best_len_q >= $past(best_len_q)));

endmodule

// File: rtl/sdtune_retune.sv
module sdtune_retune #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              due
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             due_q, due_d;
  logic [CNT_W:0]   period;
  logic             hit, adv;

  always_comb begin
    period = (code == '0) ? '0 : ((CNT_W+1)'(1) << (code - 1'b1));
    adv    = tick && (code != '0) && !due_q;
    hit    = (({1'b0, cnt_q} + 1'b1) == period);
    cnt_d  = cnt_q;
    due_d  = due_q;
    if (clr) begin
      cnt_d = '0;
      due_d = 1'b0;
    end else if (adv) begin
      if (hit) begin
        cnt_d = '0;
        due_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else if (clr | adv) begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign due = due_q;

  // R11
  retune_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(due_q) |-> ($past(tick) && $past(code) != '0));

endmodule

// File: rtl/sdtune_seq.sv
module sdtune_seq #(
  parameter int NUM_TAPS    = 16,
  parameter int MAX_ITER    = 40,
  parameter int DEFAULT_TAP = 8,
  parameter int SHORT_LEN   = 64,
  parameter int LONG_LEN    = 128,
  parameter int PAT_MUL     = 37,
  parameter int PAT_ADD     = 90,
  parameter int CNT_W       = 16,
  parameter int CODE_W      = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_wr,
  input  logic                        ctl_exec,
  input  logic                        ctl_tuned,
  input  logic                        wide_mode,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_byte,
  input  logic                        rt_tick,
  input  logic [CODE_W-1:0]           rt_code,
  output logic                        exec_busy,
  output logic                        tuned_ok,
  output logic [$clog2(NUM_TAPS)-1:0] tap_sel,
  output logic                        data_avail,
  output logic                        retune_due
);
  import sdtune_pkg::*;

  localparam int TAP_W  = $clog2(NUM_TAPS);
  localparam int LEN_W  = $clog2(NUM_TAPS + 1);
  localparam int ITER_W = $clog2(MAX_ITER);
  localparam logic [TAP_W-1:0]  TAP_LAST  = TAP_W'(NUM_TAPS - 1);
  localparam logic [TAP_W-1:0]  TAP_DEF   = TAP_W'(DEFAULT_TAP);
  localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER - 1);

  tune_st_e              st_q, st_d;
  logic [TAP_W-1:0]      tap_q, tap_d, scan_q, scan_d, final_q, final_d;
  logic [ITER_W-1:0]     iter_q, iter_d;
  logic [NUM_TAPS-1:0]   map_q, map_d;
  logic                  tuned_q, tuned_d, dav_q;

  logic                  start, sw_wr, recv, scan, sweep_end, scan_last;
  logic                  blk_done, blk_pass, pass_bit;
  logic [TAP_W-1:0]      res_start;
  logic [LEN_W-1:0]      res_len;

  always_comb begin
    start     = ctl_wr && ctl_exec && (st_q == ST_IDLE);
    sw_wr     = ctl_wr && !ctl_exec && (st_q == ST_IDLE);
    recv      = (st_q == ST_RECV);
    scan      = (st_q == ST_SCAN);
    scan_last = scan && (scan_q == TAP_LAST);
    pass_bit  = map_q[scan_q];
  end

  sdtune_blk_check #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)
  ) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(recv), .wide(wide_mode),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .blk_done(blk_done), .blk_pass(blk_pass)
  );

  sdtune_run_scan #(.NUM_TAPS(NUM_TAPS)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr(start), .step(scan),
    .pass_bit(pass_bit), .pos(scan_q),
    .res_start(res_start), .res_len(res_len)
  );

  sdtune_retune #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_rt (
    .clk(clk), .rst_n(rst_n), .clr(start || !tuned_q),
    .tick(rt_tick), .code(rt_code), .due(retune_due)
  );

  always_comb begin
    sweep_end = blk_done && (iter_q == ITER_LAST || tap_q == TAP_LAST);
    st_d    = st_q;
    tap_d   = tap_q;
    iter_d  = iter_q;
    map_d   = map_q;
    scan_d  = scan_q;
    tuned_d = tuned_q;
    final_d = final_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_RECV;
          tap_d   = '0;
          iter_d  = '0;
          map_d   = '0;
          tuned_d = 1'b0;
        end else if (sw_wr) begin
          tuned_d = tuned_q & ctl_tuned;
        end
      end
      ST_RECV: begin
        if (blk_done) begin
          map_d[tap_q] = blk_pass;
          if (sweep_end) begin
            st_d   = ST_SCAN;
            scan_d = '0;
          end else begin
            tap_d  = tap_q + 1'b1;
            iter_d = iter_q + 1'b1;
          end
        end
      end
      ST_SCAN: begin
        scan_d = scan_q + 1'b1;
        if (scan_last) begin
          st_d = ST_IDLE;
          if (res_len != '0) begin
            tuned_d = 1'b1;
            final_d = res_start + TAP_W'((res_len - 1'b1) >> 1);
          end else begin
            tuned_d = 1'b0;
            final_d = TAP_DEF;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tap_q   <= '0;
      iter_q  <= '0;
      map_q   <= '0;
      scan_q  <= '0;
      tuned_q <= 1'b0;
      final_q <= TAP_DEF;
      dav_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      tap_q   <= tap_d;
      iter_q  <= iter_d;
      map_q   <= map_d;
      scan_q  <= scan_d;
      tuned_q <= tuned_d;
      final_q <= final_d;
      dav_q   <= blk_done;
    end
  end

  assign exec_busy  = (st_q != ST_IDLE);
  assign tuned_ok   = tuned_q;
  assign data_avail = dav_q;
  assign tap_sel    = recv ? tap_q : (tuned_q ? final_q : TAP_DEF);

  // R5
  dav_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> ($past(st_q) == ST_RECV));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_busy) |-> (!tuned_ok && tap_sel == '0));

  // R9
  tuned_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(exec_busy) && tuned_ok) |-> ($past(map_q) != '0));

  // R7
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recv |-> (iter_q <= ITER_LAST && tap_q <= TAP_LAST));

endmodule

// File: tb/tb_sdtune_seq.sv
module tb_sdtune_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;
  localparam int MI = 8;
  localparam int DT = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr, ctl_exec, ctl_tuned, wide_mode, rx_valid, rt_tick;
  logic [7:0] rx_byte;
  logic [4:0] rt_code;
  logic       exec_busy, tuned_ok, data_avail, retune_due;
  logic [3:0] tap_sel;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done_flag = 0;

  // behavioural reference state
  int m_busy, m_eval, m_tap, m_iter, m_byte, m_bad, m_left;
  int m_tuned, m_final, m_dav, m_rt, m_due;
  int pass_m[NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdtune_seq #(
    .NUM_TAPS(NT), .MAX_ITER(MI), .DEFAULT_TAP(DT), .CNT_W(8), .CODE_W(5)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_exec(ctl_exec),
    .ctl_tuned(ctl_tuned), .wide_mode(wide_mode), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rt_tick(rt_tick), .rt_code(rt_code),
    .exec_busy(exec_busy), .tuned_ok(tuned_ok), .tap_sel(tap_sel),
    .data_avail(data_avail), .retune_due(retune_due)
  );

  function automatic int exp_byte(int i);
    return (37 * i + 90) % 256;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_eval = 0; m_tap = 0; m_iter = 0; m_byte = 0; m_bad = 0;
      m_left = 0; m_tuned = 0; m_final = DT; m_dav = 0; m_rt = 0; m_due = 0;
      foreach (pass_m[k]) pass_m[k] = 0;
    end else begin
      int st;
      int len;
      st = (ctl_wr && ctl_exec && !m_busy) ? 1 : 0;
      if (!m_tuned || st) begin
        m_rt = 0; m_due = 0;
      end else if (rt_tick && rt_code != 0 && !m_due) begin
        m_rt++;
        if (m_rt == (1 << (rt_code - 1))) begin m_due = 1; m_rt = 0; end
      end
      m_dav = 0;
      if (!m_busy) begin
        if (st) begin
          m_busy = 1; m_eval = 0; m_tap = 0; m_iter = 0; m_byte = 0;
          m_bad = 0; m_tuned = 0;
          foreach (pass_m[k]) pass_m[k] = 0;
        end else if (ctl_wr && !ctl_exec) begin
          m_tuned = (m_tuned && ctl_tuned) ? 1 : 0;
        end
      end else if (!m_eval) begin
        if (rx_valid) begin
          len = wide_mode ? 128 : 64;
          if (int'(rx_byte) != exp_byte(m_byte)) m_bad = 1;
          if (m_byte == len - 1) begin
            pass_m[m_tap] = m_bad ? 0 : 1;
            m_dav = 1; m_byte = 0; m_bad = 0;
            m_iter++; m_tap++;
            if (m_iter == MI || m_tap == NT) begin m_eval = 1; m_left = NT; end
          end else begin
            m_byte++;
          end
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          int run, best, bs;
          run = 0; best = 0; bs = 0;
          for (int k = 0; k < NT; k++) begin
            run = pass_m[k] ? run + 1 : 0;
            if (run > best) begin best = run; bs = k - run + 1; end
          end
          m_tuned = (best > 0) ? 1 : 0;
          m_final = (best > 0) ? bs + (best - 1) / 2 : DT;
          m_busy = 0; m_eval = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int expv);
    vectors++;
    if (act != expv) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  task automatic step();
    int mtap;
    @(negedge clk);
    mtap = (m_busy && !m_eval) ? m_tap : (m_tuned ? m_final : DT);
    chk("R2 exec_busy", int'(exec_busy), m_busy);
    chk("R8 tuned_ok", int'(tuned_ok), m_tuned);
    chk("R6 tap_sel", int'(tap_sel), mtap);
    chk("R5 data_avail", int'(data_avail), m_dav);
    chk("R11 retune_due", int'(retune_due), m_due);
  endtask

  task automatic wr(logic e, logic t);
    ctl_wr = 1'b1; ctl_exec = e; ctl_tuned = t;
    step();
    ctl_wr = 1'b0; ctl_exec = 1'b0; ctl_tuned = 1'b0;
  endtask

  // sends bytes lo..hi of a block; flips one bit at position bad (-1: none)
  task automatic send_range(int lo, int hi, int bad);
    for (int i = lo; i <= hi; i++) begin
      rx_valid = 1'b1;
      rx_byte  = 8'(exp_byte(i) ^ ((i == bad) ? 1 : 0));
      step();
    end
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
  endtask

  task automatic send_block(int len, int bad);
    send_range(0, len - 1, bad);
    chk("R5 pulse after last byte", int'(data_avail), 1);
    step();
    chk("R5 pulse one cycle", int'(data_avail), 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && exec_busy; i++) step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 0; ctl_exec = 0; ctl_tuned = 0; wide_mode = 0;
    rx_valid = 0; rx_byte = 0; rt_tick = 0; rt_code = 0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 busy", int'(exec_busy), 0);
    chk("R1 tuned", int'(tuned_ok), 0);
    chk("R1 tap", int'(tap_sel), DT);
    chk("R1 retune", int'(retune_due), 0);

    // sweep A: narrow, passes at 2,3,4,5,7 -> centre 3
    wr(1, 0);
    chk("R2 busy after start", int'(exec_busy), 1);
    chk("R2 tap starts at 0", int'(tap_sel), 0);
    for (int b = 0; b < MI; b++) begin
      send_block(64, (b == 2 || b == 3 || b == 4 || b == 5 || b == 7) ? -1 : (b * 9) % 64);
      if (b == 3) begin
        wr(0, 0);
        wr(1, 0);
        chk("R10 writes while busy ignored", int'(tap_sel), 4);
        chk("R6 tap advanced", int'(exec_busy), 1);
      end
    end
    chk("R7 still evaluating", int'(exec_busy), 1);
    wait_idle();
    chk("R7 busy falls", int'(exec_busy), 0);
    chk("R8 longest run centre", int'(tap_sel), 3);
    chk("R8 tuned set", int'(tuned_ok), 1);
    rt_tick = 1'b1;
    for (int i = 0; i < 12; i++) step();
    rt_tick = 1'b0;
    chk("R11 code zero never due", int'(retune_due), 0);
    send_range(0, 63, -1);
    step();
    chk("R5 idle bytes ignored", int'(tap_sel), 3);

    // sweep B: wide, passes at 0,1 and 5,6 -> tie, lower wins -> 0
    wide_mode = 1'b1;
    wr(1, 0);
    chk("R2 tuned cleared on start", int'(tuned_ok), 0);
    send_range(0, 63, -1);
    chk("R3 no pulse at 64 in wide mode", int'(data_avail), 0);
    send_range(64, 127, -1);
    chk("R3 pulse at 128", int'(data_avail), 1);
    step();
    for (int b = 1; b < MI; b++)
      send_block(128, (b == 1 || b == 5 || b == 6) ? -1 : 100 + b);
    wait_idle();
    chk("R8 tie picks lowest run", int'(tap_sel), 0);
    wide_mode = 1'b0;

    // sweep C: every block corrupted at a different byte
    wr(1, 0);
    for (int b = 0; b < MI; b++) send_block(64, 63 - b);
    wait_idle();
    chk("R9 tuned stays clear", int'(tuned_ok), 0);
    chk("R9 default tap", int'(tap_sel), DT);
    chk("R4 corrupted blocks fail", int'(exec_busy), 0);

    // sweep D: only the last tried tap passes -> 7
    wr(1, 0);
    for (int b = 0; b < MI; b++) send_block(64, (b == 7) ? -1 : 0);
    wait_idle();
    chk("R4 single passing tap", int'(tap_sel), 7);
    rt_code = 5'd3;
    rt_tick = 1'b1;
    step(); step(); step();
    chk("R11 not due at 3 ticks", int'(retune_due), 0);
    step();
    chk("R11 due at 4 ticks", int'(retune_due), 1);
    rt_tick = 1'b0;
    wr(0, 1);
    chk("R10 keep write no change", int'(tuned_ok), 1);
    chk("R10 keep write tap", int'(tap_sel), 7);
    wr(0, 0);
    chk("R10 clear drops tuned", int'(tuned_ok), 0);
    chk("R10 clear falls back", int'(tap_sel), DT);
    step();
    chk("R11 due cleared with tuned", int'(retune_due), 0);
    step();
    finish_run();
  end

endmodule